// File: doc/BRIEF.md
# Pipelined Configuration Register File

This block holds a small set of configuration and status registers that are driven by a stream of instructions, one per clock, on a single fast clock. Each instruction carries a valid flag, a write flag, a 3-bit word address and 32 bits of write data. Writes land on the clock edge that accepts them. Reads go through a registered two-level selection: the first level picks a pair of words using the upper address bits, and the second level uses the delayed lowest address bit to pick one word of the pair. Read data therefore appears a fixed two cycles after the request. Because every stage advances every cycle, back-to-back reads stream out in request order.

Some addresses start an action instead of storing a value. One address clears an internal event counter and emits a one-cycle clear strobe. Another emits a one-cycle flush strobe. A third address ORs its data into a sticky interrupt-acknowledge mask. A sampled copy of a 32-bit interrupt-pending input is read back through that mask.

Top module: `cfg_regfile`

## Requirements
- R1: After a synchronous active-high reset, `rd_valid_o`, `cnt_clr_o`, `flush_o`, `param_o` and `aux_o` are all zero. The acknowledge mask, the event counter and the sampled interrupt copy are also zero.
- R2: A read of address 0 returns the constant `VERSION` parameter. A write to address 0 changes nothing.
- R3: Addresses 1 and 3 are plain read/write words. Their contents are also shown on `param_o` (address 1) and `aux_o` (address 3) from the cycle after the write.
- R4: A write to address 2 ORs the write data into the acknowledge mask. No write can clear a mask bit; only reset clears it.
- R5: `irq_pending_i` is registered on every clock. A read of address 2 returns that registered copy ANDed with the inverse of the acknowledge mask, as they stand when the read is accepted.
- R6: A read accepted at clock edge N gives `rd_valid_o` high with its data after edge N+1. A new instruction can be accepted on every edge, and responses come out in request order. `rd_valid_o` is low in every cycle that has no matching request.
- R7: A write to address 4 sets the event counter to zero on the accepting edge, even if `event_i` is high in that cycle. It also drives `cnt_clr_o` high for exactly the following cycle. Reads of address 4 return zero.
- R8: A write to address 5 drives `flush_o` high for exactly the following cycle. Reads of address 5 return zero.
- R9: The event counter increases by one on every edge where `event_i` is high and no clear is written. Address 6 reads the counter value from before the accepting edge.
- R10: Address 7 always reads zero, and writes to it change nothing.
- R11: While `instr_valid_i` is low, the write flag, address and data have no effect on any register or strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid_i | input | 1 | Instruction present this cycle |
| instr_wr_i | input | 1 | 1 = write, 0 = read |
| instr_addr_i | input | 3 | Word address |
| instr_wdata_i | input | 32 | Write data |
| irq_pending_i | input | 32 | Interrupt-pending bits, sampled each clock |
| event_i | input | 1 | Event to be counted |
| rd_valid_o | output | 1 | Read response valid |
| rd_data_o | output | 32 | Read response data |
| param_o | output | 32 | Contents of address 1 |
| aux_o | output | 32 | Contents of address 3 |
| cnt_clr_o | output | 1 | One-cycle counter-clear strobe |
| flush_o | output | 1 | One-cycle flush strobe |

## Verification
The hardest case to reach is a read that depends on a write accepted one edge earlier. The two read stages must then carry the new value, and the delayed low address bit must still belong to the word in flight. A clear that lands on the same edge as an event is just as hard. The stimulus places write/read pairs back to back on every address, and it holds `event_i` high across a clear. A long random phase then mixes reads, writes, idle slots and interrupt changes on every clock. A behavioural model predicts each cycle's outputs and compares them on the opposite clock edge.

// File: rtl/cfg_regfile_pkg.sv
package cfg_regfile_pkg;
    localparam int ADDR_W = 3;
    localparam int NUM_WORDS = 1 << ADDR_W;

    typedef enum logic [ADDR_W-1:0] {
        ADR_VERSION = 3'd0,
        ADR_PARAM   = 3'd1,
        ADR_IRQ_ACK = 3'd2,
        ADR_AUX     = 3'd3,
        ADR_CNT_CLR = 3'd4,
        ADR_FLUSH   = 3'd5,
        ADR_EVT_CNT = 3'd6,
        ADR_SPARE   = 3'd7
    } reg_addr_e;
endpackage

// File: rtl/cfg_regfile_wr.sv
module cfg_regfile_wr
    import cfg_regfile_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter logic [DATA_W-1:0] VERSION = '0
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               wr_en,
    input  logic [ADDR_W-1:0]                  addr,
    input  logic [DATA_W-1:0]                  wdata,
    input  logic [DATA_W-1:0]                  irq_pending,
    input  logic                               event_in,
    output logic [NUM_WORDS-1:0][DATA_W-1:0]   words,
    output logic [DATA_W-1:0]                  param_q,
    output logic [DATA_W-1:0]                  aux_q,
    output logic                               clr_pulse,
    output logic                               flush_pulse
);
    logic [DATA_W-1:0] ack_q;
    logic [DATA_W-1:0] irq_q;
    logic [DATA_W-1:0] evt_cnt_q;
    logic              clr_hit;
    logic              flush_hit;

    assign clr_hit   = wr_en && (addr == ADR_CNT_CLR);
    assign flush_hit = wr_en && (addr == ADR_FLUSH);

    always_ff @(posedge clk) begin
        if (rst) begin
            param_q     <= '0;
            aux_q       <= '0;
            ack_q       <= '0;
            irq_q       <= '0;
            evt_cnt_q   <= '0;
            clr_pulse   <= 1'b0;
            flush_pulse <= 1'b0;
        end else begin
            irq_q       <= irq_pending;
            clr_pulse   <= clr_hit;
            flush_pulse <= flush_hit;
            if (wr_en) begin
                unique case (reg_addr_e'(addr))
                    ADR_PARAM:   param_q <= wdata;
                    ADR_IRQ_ACK: ack_q   <= ack_q | wdata;
                    ADR_AUX:     aux_q   <= wdata;
                    default:     ;
                endcase
            end
            if (clr_hit) begin
                evt_cnt_q <= '0;
            end else if (event_in) begin
                evt_cnt_q <= evt_cnt_q + 1'b1;
            end
        end
    end

    always_comb begin
        words              = '0;
        words[ADR_VERSION] = VERSION;
        words[ADR_PARAM]   = param_q;
        words[ADR_IRQ_ACK] = irq_q & ~ack_q;
        words[ADR_AUX]     = aux_q;
        words[ADR_EVT_CNT] = evt_cnt_q;
    end

    assert_ack_sticky_R4: assert property (@(posedge clk) disable iff (rst)
        (ack_q & $past(ack_q)) == $past(ack_q));

    assert_clear_wins_R7: assert property (@(posedge clk) disable iff (rst)
        clr_hit |=> (evt_cnt_q == '0));

    assert_clr_pulse_src_R7: assert property (@(posedge clk) disable iff (rst)
        clr_pulse |-> $past(wr_en && addr == ADR_CNT_CLR));

    assert_flush_pulse_src_R8: assert property (@(posedge clk) disable iff (rst)
        flush_pulse |-> $past(wr_en && addr == ADR_FLUSH));

    assert_count_step_R9: assert property (@(posedge clk) disable iff (rst)
        (!clr_hit && event_in) |=> (evt_cnt_q == $past(evt_cnt_q) + 1'b1));
endmodule

// File: rtl/cfg_regfile_rdpipe.sv
module cfg_regfile_rdpipe
    import cfg_regfile_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             rd_en,
    input  logic [ADDR_W-1:0]                addr,
    input  logic [NUM_WORDS-1:0][DATA_W-1:0] words,
    output logic                             rd_valid,
    output logic [DATA_W-1:0]                rd_data
);
    localparam int PAIRS  = NUM_WORDS / 2;
    localparam int PAIR_W = ADDR_W - 1;

    logic [PAIRS-1:0][DATA_W-1:0] even_w;
    logic [PAIRS-1:0][DATA_W-1:0] odd_w;
    logic [DATA_W-1:0]            s1_even;
    logic [DATA_W-1:0]            s1_odd;
    logic                         s1_valid;
    logic                         s1_lo;
    logic [PAIR_W-1:0]            pair_sel;

    for (genvar g = 0; g < PAIRS; g++) begin : g_pair
        assign even_w[g] = words[2*g];
        assign odd_w[g]  = words[2*g+1];
    end

    assign pair_sel = addr[ADDR_W-1:1];

    // Stage one: the upper address bits pick a pair of words.
    always_ff @(posedge clk) begin
        if (rst) begin
            s1_valid <= 1'b0;
            s1_lo    <= 1'b0;
            s1_even  <= '0;
            s1_odd   <= '0;
        end else begin
            s1_valid <= rd_en;
            s1_lo    <= addr[0];
            if (rd_en) begin
                s1_even <= even_w[pair_sel];
                s1_odd  <= odd_w[pair_sel];
            end
        end
    end

    // Stage two: the delayed low address bit picks one word of the pair.
    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= s1_valid;
            if (s1_valid) begin
                rd_data <= s1_lo ? s1_odd : s1_even;
            end
        end
    end

    assert_read_latency_R6: assert property (@(posedge clk) disable iff (rst)
        rd_en |=> ##1 rd_valid);

    assert_no_spurious_valid_R6: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> ##1 !rd_valid);
endmodule

// File: rtl/cfg_regfile.sv
module cfg_regfile
    import cfg_regfile_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter logic [DATA_W-1:0] VERSION = 32'h0001_0203
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              instr_valid_i,
    input  logic              instr_wr_i,
    input  logic [ADDR_W-1:0] instr_addr_i,
    input  logic [DATA_W-1:0] instr_wdata_i,
    input  logic [DATA_W-1:0] irq_pending_i,
    input  logic              event_i,
    output logic              rd_valid_o,
    output logic [DATA_W-1:0] rd_data_o,
    output logic [DATA_W-1:0] param_o,
    output logic [DATA_W-1:0] aux_o,
    output logic              cnt_clr_o,
    output logic              flush_o
);
    logic                             wr_en;
    logic                             rd_en;
    logic [NUM_WORDS-1:0][DATA_W-1:0] words;

    assign wr_en = instr_valid_i && instr_wr_i;
    assign rd_en = instr_valid_i && !instr_wr_i;

    cfg_regfile_wr #(.DATA_W(DATA_W), .VERSION(VERSION)) u_wr (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (wr_en),
        .addr        (instr_addr_i),
        .wdata       (instr_wdata_i),
        .irq_pending (irq_pending_i),
        .event_in    (event_i),
        .words       (words),
        .param_q     (param_o),
        .aux_q       (aux_o),
        .clr_pulse   (cnt_clr_o),
        .flush_pulse (flush_o)
    );

    cfg_regfile_rdpipe #(.DATA_W(DATA_W)) u_rd (
        .clk      (clk),
        .rst      (rst),
        .rd_en    (rd_en),
        .addr     (instr_addr_i),
        .words    (words),
        .rd_valid (rd_valid_o),
        .rd_data  (rd_data_o)
    );

    assert_idle_no_write_R11: assert property (@(posedge clk) disable iff (rst)
        !instr_valid_i |=> ($stable(param_o) && $stable(aux_o) && !cnt_clr_o && !flush_o));
endmodule

// File: tb/cfg_regfile_tb.sv
`timescale 1ns/1ps
module cfg_regfile_tb;
    localparam logic [31:0] VER = 32'h0001_0203;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        iv = 1'b0, iw = 1'b0;
    logic [2:0]  ia = '0;
    logic [31:0] id = '0;
    logic [31:0] irq = '0;
    logic        evt = 1'b0;
    logic        rd_valid_o, cnt_clr_o, flush_o;
    logic [31:0] rd_data_o, param_o, aux_o;

    int errors = 0;
    int checks = 0;

    always #2.5 clk = ~clk;

    cfg_regfile #(.DATA_W(32), .VERSION(VER)) u_dut (
        .clk(clk), .rst(rst), .instr_valid_i(iv), .instr_wr_i(iw),
        .instr_addr_i(ia), .instr_wdata_i(id), .irq_pending_i(irq),
        .event_i(evt), .rd_valid_o(rd_valid_o), .rd_data_o(rd_data_o),
        .param_o(param_o), .aux_o(aux_o), .cnt_clr_o(cnt_clr_o), .flush_o(flush_o)
    );

    // Behavioural reference model.
    logic [31:0] m_param, m_aux, m_ack, m_irq, m_cnt, r;
    logic        pend_v, out_v, exp_clr, exp_flush;
    logic [31:0] pend_d, out_d;
    string       pend_t, out_t, t;

    always @(posedge clk) begin
        if (rst) begin
            m_param = 0; m_aux = 0; m_ack = 0; m_irq = 0; m_cnt = 0;
            pend_v = 0; out_v = 0; exp_clr = 0; exp_flush = 0;
            pend_d = 0; out_d = 0; pend_t = "R6"; out_t = "R6";
        end else begin
            case (ia)
                3'd0: begin r = VER;             t = "R2";  end
                3'd1: begin r = m_param;         t = "R3";  end
                3'd2: begin r = m_irq & ~m_ack;  t = "R5";  end
                3'd3: begin r = m_aux;           t = "R3";  end
                3'd4: begin r = 0;               t = "R7";  end
                3'd5: begin r = 0;               t = "R8";  end
                3'd6: begin r = m_cnt;           t = "R9";  end
                default: begin r = 0;            t = "R10"; end
            endcase
            out_v = pend_v; out_d = pend_d; out_t = pend_t;
            pend_v = iv && !iw; pend_d = r; pend_t = t;
            exp_clr   = iv && iw && ia == 3'd4;
            exp_flush = iv && iw && ia == 3'd5;
            m_irq = irq;
            if (iv && iw) begin
                if (ia == 3'd1) m_param = id;
                if (ia == 3'd2) m_ack = m_ack | id;
                if (ia == 3'd3) m_aux = id;
            end
            if (exp_clr) m_cnt = 0;
            else if (evt) m_cnt = m_cnt + 1;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s at %0t: actual=%h expected=%h", tag, $time, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            chk(rd_valid_o == out_v, "R6", 32'(rd_valid_o), 32'(out_v));
            if (out_v) chk(rd_data_o == out_d, out_t, rd_data_o, out_d);
            chk(cnt_clr_o == exp_clr, "R7", 32'(cnt_clr_o), 32'(exp_clr));
            chk(flush_o == exp_flush, "R8", 32'(flush_o), 32'(exp_flush));
            chk(param_o == m_param, "R3", param_o, m_param);
            chk(aux_o == m_aux, "R3", aux_o, m_aux);
        end
    end

    task automatic op(input logic v, input logic w, input logic [2:0] a, input logic [31:0] d);
        iv = v; iw = w; ia = a; id = d;
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state visible at the ports
        chk(rd_valid_o == 0, "R1", 32'(rd_valid_o), 0);
        chk(param_o == 0 && aux_o == 0, "R1", param_o | aux_o, 0);
        chk(cnt_clr_o == 0 && flush_o == 0, "R1", 32'(cnt_clr_o | flush_o), 0);
        op(1, 0, 3'd6, 0);                  // R1 counter reads zero
        op(1, 0, 3'd2, 0);                  // R1 masked irq reads zero
        // R2 version constant, write ignored
        op(1, 0, 3'd0, 0);
        op(1, 1, 3'd0, 32'hFFFF_FFFF);
        op(1, 0, 3'd0, 0);
        // R3 write then immediate read on both plain words
        op(1, 1, 3'd1, 32'hA5A5_1234);
        op(1, 0, 3'd1, 0);
        op(1, 1, 3'd3, 32'h0BAD_F00D);
        op(1, 0, 3'd3, 0);
        op(1, 0, 3'd1, 0);
        // R5/R4 interrupt masking and stickiness
        irq = 32'h0000_00F0;
        op(1, 0, 3'd2, 0);
        op(1, 0, 3'd2, 0);
        op(1, 1, 3'd2, 32'h0000_0030);
        op(1, 0, 3'd2, 0);
        op(1, 1, 3'd2, 32'h0);
        op(1, 0, 3'd2, 0);
        irq = 32'hFFFF_0000;
        op(0, 0, 3'd0, 0);
        op(1, 0, 3'd2, 0);
        // R9 counting, R7 clear wins over event
        evt = 1;
        repeat (5) op(1, 0, 3'd6, 0);
        op(1, 1, 3'd4, 0);
        op(1, 0, 3'd6, 0);
        op(1, 0, 3'd6, 0);
        evt = 0;
        op(1, 0, 3'd6, 0);
        // R8 flush strobes back to back, action addresses read zero
        op(1, 1, 3'd5, 32'h1);
        op(1, 1, 3'd5, 32'h1);
        op(1, 0, 3'd4, 0);
        op(1, 0, 3'd5, 0);
        // R10 spare word ignores writes
        op(1, 1, 3'd7, 32'hDEAD_BEEF);
        op(1, 0, 3'd7, 0);
        // R11 idle slot with write fields set changes nothing
        op(0, 1, 3'd1, 32'h0);
        op(0, 1, 3'd4, 32'h0);
        op(0, 0, 3'd0, 0);
        chk(param_o == 32'hA5A5_1234, "R11", param_o, 32'hA5A5_1234);
        chk(cnt_clr_o == 0, "R11", 32'(cnt_clr_o), 0);
        // Mixed random traffic, compared every cycle by the model
        for (int i = 0; i < 3000; i++) begin
            irq = (i % 7 == 0) ? $urandom : irq;
            evt = $urandom_range(0, 1);
            op($urandom_range(0, 3) != 0, $urandom_range(0, 2) == 0,
               3'($urandom_range(0, 7)), $urandom & $urandom & $urandom);
        end
        op(0, 0, 3'd0, 0);
        op(0, 0, 3'd0, 0);
        op(0, 0, 3'd0, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule